// File: doc/BRIEF.md
# Combinational Sliding-Attack Detector

This block looks at the full state of a chessboard and reports at once which squares are attacked along straight lines by rooks, bishops and queens. The board arrives as a wide flat vector, thirteen lines per square. Each square's group is one-hot: one line says the square is empty, or one of the twelve lines names the piece standing there.

For every target square and each of eight ray directions, the block raises one flag per colour. The flag is set when the first occupied square met while walking outward along that ray holds a slider of that colour able to move along the ray. Every square passed before that must be empty. Each flag is a sum of products. There is one product per candidate attacker square on the ray, and each product is gated by the empty lines of all nearer squares.

Two summary vectors OR the eight directional flags of each square, one vector per colour. There is no clock and no storage, so every output follows the current board after gate delay only. Knight, king and pawn attacks are not computed. No check is made of whether a position is legal.

Top module: `bsa_board_attack`

## Requirements
- R1: Square s (a1 = 0, b1 = 1, …, h1 = 7, a2 = 8, …, h8 = 63, so file = s mod 8 and rank = s div 8) owns input bits board_i[s*13 +: 13]. Within the group, line 0 means empty. Lines 1 to 6 are the white pawn, knight, bishop, rook, queen and king. Lines 7 to 12 are the same six pieces for black. An all-empty board gives all outputs 0.
- R2: All outputs are combinational functions of board_i alone. A new board is reflected in every output within the same clock period it is applied, with no cycle of latency.
- R3: A slider of a colour on the square next to the target, in a direction it moves along, sets that colour's flag for that direction, whatever lies beyond it.
- R4: Only the nearest occupied square on a ray decides the flag. Empty squares are passed through. Any other piece blocks the ray, including pawns, knights, kings and sliders of the wrong kind or colour.
- R5: North, south, east and west accept a rook or a queen. The four diagonals accept a bishop or a queen. Pawns, knights and kings never set a flag.
- R6: Direction codes are 0 = north (rank+1), 1 = south, 2 = east (file+1), 3 = west, 4 = north-east, 5 = north-west, 6 = south-east and 7 = south-west. The flag for target s and direction d sits at bit s*8+d of the per-colour directional output. It means the attacker lies in direction d from s.
- R7: A direction in which the target square has no neighbour on the board always gives a 0 flag.
- R8: White flags depend only on white sliders, and black flags depend only on black sliders. With no slider of a colour on the board, all flags of that colour are 0.
- R9: The per-square summary of a colour is the OR of that colour's eight directional flags for the square.
- R10: Square a8 is flagged as attacked from the south by white when a white rook stands on a1 and a2 to a7 are empty. A white pawn on a4 removes that flag, while a3 stays flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| board_i | input | 832 | Board state, 13 one-hot lines per square |
| atk_dir_w_o | output | 512 | White directional flags, bit s*8+d |
| atk_dir_b_o | output | 512 | Black directional flags, bit s*8+d |
| atk_w_o | output | 64 | Square attacked by any white slider |
| atk_b_o | output | 64 | Square attacked by any black slider |

## Verification
The block holds no state, so a faulty internal net shows up directly. Examples are a dropped empty gate, a wrong attacker line or a miswired neighbour. Such a fault turns into a wrong flag for the very board that exercises it, in the same period that board is applied. A missing empty condition lets a blocked piece leak through to every square beyond the blocker on that ray. A wrong neighbour index moves a flag to a different bit position. Both faults are exposed by comparing the whole directional vectors against a walk along the rays, for hand-placed and randomly filled boards.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  localparam int BOARD_W = 8;
  localparam int NSQ     = BOARD_W * BOARD_W;
  localparam int NLINE   = 13;
  localparam int NDIR    = 8;
  localparam int NORTH_DIRS = 4;

  localparam int L_EMPTY = 0;
  localparam int L_WP = 1;
  localparam int L_WN = 2;
  localparam int L_WB = 3;
  localparam int L_WR = 4;
  localparam int L_WQ = 5;
  localparam int L_WK = 6;
  localparam int L_BP = 7;
  localparam int L_BN = 8;
  localparam int L_BB = 9;
  localparam int L_BR = 10;
  localparam int L_BQ = 11;
  localparam int L_BK = 12;

  typedef enum logic [2:0] {
    DIR_N, DIR_S, DIR_E, DIR_W, DIR_NE, DIR_NW, DIR_SE, DIR_SW
  } dir_e;

  function automatic int dir_df(int d);
    case (dir_e'(d[2:0]))
      DIR_E, DIR_NE, DIR_SE: return 1;
      DIR_W, DIR_NW, DIR_SW: return -1;
      default:               return 0;
    endcase
  endfunction

  function automatic int dir_dr(int d);
    case (dir_e'(d[2:0]))
      DIR_N, DIR_NE, DIR_NW: return 1;
      DIR_S, DIR_SE, DIR_SW: return -1;
      default:               return 0;
    endcase
  endfunction

  function automatic bit dir_is_diag(int d);
    return d >= NORTH_DIRS;
  endfunction

  // Square reached after k steps from sq in direction d, or -1 if off board.
  function automatic int ray_sq(int sq, int d, int k);
    int f;
    int r;
    f = (sq % BOARD_W) + k * dir_df(d);
    r = (sq / BOARD_W) + k * dir_dr(d);
    if (f < 0 || f >= BOARD_W || r < 0 || r >= BOARD_W) return -1;
    return r * BOARD_W + f;
  endfunction

  function automatic int ray_len(int sq, int d);
    int n;
    n = 0;
    for (int k = 1; k < BOARD_W; k++)
      if (ray_sq(sq, d, k) >= 0) n = k;
    return n;
  endfunction
endpackage

// File: rtl/bsa_cell_decode.sv
module bsa_cell_decode
  import bsa_pkg::*;
(
  input  logic [NLINE-1:0] cell_i,
  output logic             empty_o,
  output logic             w_orth_o,
  output logic             w_diag_o,
  output logic             b_orth_o,
  output logic             b_diag_o,
  output logic             blocker_o
);
  logic any_slider_w;
  logic plain_piece_w;

  assign empty_o  = cell_i[L_EMPTY];
  assign w_orth_o = cell_i[L_WR] | cell_i[L_WQ];
  assign w_diag_o = cell_i[L_WB] | cell_i[L_WQ];
  assign b_orth_o = cell_i[L_BR] | cell_i[L_BQ];
  assign b_diag_o = cell_i[L_BB] | cell_i[L_BQ];

  assign any_slider_w  = cell_i[L_WB] | cell_i[L_WR] | cell_i[L_WQ] |
                         cell_i[L_BB] | cell_i[L_BR] | cell_i[L_BQ];
  assign plain_piece_w = cell_i[L_WP] | cell_i[L_WN] | cell_i[L_WK] |
                         cell_i[L_BP] | cell_i[L_BN] | cell_i[L_BK];
  // Occupied by something that can never be a ray attacker.
  assign blocker_o = plain_piece_w & ~any_slider_w & ~cell_i[L_EMPTY];
endmodule

// File: rtl/bsa_slider_ray.sv
module bsa_slider_ray #(
  parameter int LEN = 7
) (
  input  logic [LEN-1:0] clear_i,
  input  logic [LEN-1:0] foe_i,
  output logic           hit_o
);
  logic [LEN-1:0] term_w;

  for (genvar k = 0; k < LEN; k++) begin : g_term
    if (k == 0) begin : g_near
      assign term_w[k] = foe_i[k];
    end else begin : g_far
      assign term_w[k] = foe_i[k] & (&clear_i[k-1:0]);
    end
  end

  assign hit_o = |term_w;

  always_comb begin
    if (foe_i[0]) begin
      p_adj_hit_r3: assert (hit_o);
    end
    if (!clear_i[0] && !foe_i[0]) begin
      p_blocked_r4: assert (!hit_o);
    end
  end
endmodule

// File: rtl/bsa_square_merge.sv
module bsa_square_merge
  import bsa_pkg::*;
(
  input  logic [NDIR-1:0] w_dir_i,
  input  logic [NDIR-1:0] b_dir_i,
  output logic            atk_w_o,
  output logic            atk_b_o
);
  assign atk_w_o = |w_dir_i;
  assign atk_b_o = |b_dir_i;
endmodule

// File: rtl/bsa_board_attack.sv
module bsa_board_attack
  import bsa_pkg::*;
(
  input  logic [NSQ*NLINE-1:0] board_i,
  output logic [NSQ*NDIR-1:0]  atk_dir_w_o,
  output logic [NSQ*NDIR-1:0]  atk_dir_b_o,
  output logic [NSQ-1:0]       atk_w_o,
  output logic [NSQ-1:0]       atk_b_o
);
  logic [NSQ-1:0] empty_w, w_orth_w, w_diag_w, b_orth_w, b_diag_w, blocker_w;

  for (genvar s = 0; s < NSQ; s++) begin : g_cell
    bsa_cell_decode u_dec (
      .cell_i   (board_i[s*NLINE +: NLINE]),
      .empty_o  (empty_w[s]),
      .w_orth_o (w_orth_w[s]),
      .w_diag_o (w_diag_w[s]),
      .b_orth_o (b_orth_w[s]),
      .b_diag_o (b_diag_w[s]),
      .blocker_o(blocker_w[s])
    );
  end

  for (genvar s = 0; s < NSQ; s++) begin : g_sq
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      localparam int LEN  = ray_len(s, d);
      localparam bit DIAG = dir_is_diag(d);
      if (LEN == 0) begin : g_edge
        assign atk_dir_w_o[s*NDIR+d] = 1'b0;
        assign atk_dir_b_o[s*NDIR+d] = 1'b0;
      end else begin : g_ray
        logic [LEN-1:0] clr_v, wfoe_v, bfoe_v;
        for (genvar k = 0; k < LEN; k++) begin : g_step
          localparam int TS = ray_sq(s, d, k + 1);
          assign clr_v[k]  = empty_w[TS];
          assign wfoe_v[k] = DIAG ? w_diag_w[TS] : w_orth_w[TS];
          assign bfoe_v[k] = DIAG ? b_diag_w[TS] : b_orth_w[TS];
        end
        bsa_slider_ray #(.LEN(LEN)) u_w (
          .clear_i(clr_v), .foe_i(wfoe_v), .hit_o(atk_dir_w_o[s*NDIR+d])
        );
        bsa_slider_ray #(.LEN(LEN)) u_b (
          .clear_i(clr_v), .foe_i(bfoe_v), .hit_o(atk_dir_b_o[s*NDIR+d])
        );
      end
    end
    bsa_square_merge u_merge (
      .w_dir_i(atk_dir_w_o[s*NDIR +: NDIR]),
      .b_dir_i(atk_dir_b_o[s*NDIR +: NDIR]),
      .atk_w_o(atk_w_o[s]),
      .atk_b_o(atk_b_o[s])
    );
  end

  // Cross-ray and board-wide properties.
  always_comb begin
    int  n;
    bit  walled;
    for (int s = 0; s < NSQ; s++) begin
      walled = 1'b1;
      for (int d = 0; d < NDIR; d++) begin
        n = ray_sq(s, d, 1);
        if (n >= 0) begin
          if (!blocker_w[n]) walled = 1'b0;
          if (empty_w[n] && !w_orth_w[n] && !w_diag_w[n] &&
              !b_orth_w[n] && !b_diag_w[n]) begin
            p_ray_chain_r4: assert (
              atk_dir_w_o[s*NDIR+d] == atk_dir_w_o[n*NDIR+d] &&
              atk_dir_b_o[s*NDIR+d] == atk_dir_b_o[n*NDIR+d]);
          end
        end
      end
      if (walled) begin
        p_enclosed_r9: assert (!atk_w_o[s] && !atk_b_o[s]);
      end
    end
    if (!(|w_orth_w) && !(|w_diag_w)) begin
      p_no_white_r8: assert (atk_dir_w_o == '0);
    end
    if (!(|b_orth_w) && !(|b_diag_w)) begin
      p_no_black_r8: assert (atk_dir_b_o == '0);
    end
  end
endmodule

// File: tb/bsa_board_attack_bench.sv
module bsa_board_attack_bench;
  localparam int NSQ = 64;
  localparam int NL  = 13;
  localparam int ND  = 8;
  localparam int DF[8] = '{0, 0, 1, -1, 1, -1, 1, -1};
  localparam int DR[8] = '{1, -1, 0, 0, 1, 1, -1, -1};

  typedef struct {
    string            tag;
    logic [NSQ*ND-1:0] ew;
    logic [NSQ*ND-1:0] eb;
    logic [NSQ-1:0]    sw;
    logic [NSQ-1:0]    sb;
    int               spot;
    bit               spot_blk;
    bit               spot_val;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSQ*NL-1:0] board;
  logic [NSQ*NL-1:0] scratch;
  logic [NSQ*ND-1:0] dw, db;
  logic [NSQ-1:0]    aw, ab;
  exp_t q[$];
  int ntot = 0;
  int nbad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bsa_board_attack u_bsa_board_attack (
    .board_i(board), .atk_dir_w_o(dw), .atk_dir_b_o(db),
    .atk_w_o(aw), .atk_b_o(ab)
  );

  function automatic int code_at(logic [NSQ*NL-1:0] b, int s);
    for (int i = 0; i < NL; i++) if (b[s*NL+i]) return i;
    return 0;
  endfunction

  // Independent reference: walk each ray until the first occupied square.
  function automatic void model(input logic [NSQ*NL-1:0] b,
                                output logic [NSQ*ND-1:0] ew,
                                output logic [NSQ*ND-1:0] eb,
                                output logic [NSQ-1:0] sw,
                                output logic [NSQ-1:0] sb);
    ew = '0; eb = '0;
    for (int s = 0; s < NSQ; s++) begin
      for (int d = 0; d < ND; d++) begin
        int f;
        int r;
        int c;
        bit go;
        f = s % 8; r = s / 8; go = 1;
        while (go) begin
          f += DF[d]; r += DR[d];
          if (f < 0 || f > 7 || r < 0 || r > 7) go = 0;
          else begin
            c = code_at(b, r*8 + f);
            if (c != 0) begin
              go = 0;
              if (c == 5 || (d < 4 ? c == 4 : c == 3)) ew[s*ND+d] = 1'b1;
              if (c == 11 || (d < 4 ? c == 10 : c == 9)) eb[s*ND+d] = 1'b1;
            end
          end
        end
      end
      sw[s] = |ew[s*ND +: ND];
      sb[s] = |eb[s*ND +: ND];
    end
  endfunction

  task automatic clear_board();
    scratch = '0;
    for (int s = 0; s < NSQ; s++) scratch[s*NL] = 1'b1;
  endtask

  task automatic put(int s, int c);
    scratch[s*NL +: NL] = '0;
    scratch[s*NL + c] = 1'b1;
  endtask

  task automatic apply(string tag, int spot, bit blk, bit val);
    exp_t it;
    model(scratch, it.ew, it.eb, it.sw, it.sb);
    it.tag = tag; it.spot = spot; it.spot_blk = blk; it.spot_val = val;
    @(posedge clk);
    board <= scratch;
    q.push_back(it);
  endtask

  task automatic check_vec(string tag, string what, logic [NSQ*ND-1:0] act,
                           logic [NSQ*ND-1:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares half a period after each new board (R2).
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check_vec(it.tag, "white dir", dw, it.ew);
      check_vec(it.tag, "black dir", db, it.eb);
      check_vec(it.tag, "white sum R9", {448'b0, aw}, {448'b0, it.sw});
      check_vec(it.tag, "black sum R9", {448'b0, ab}, {448'b0, it.sb});
      if (it.spot >= 0) begin
        logic got;
        got = it.spot_blk ? db[it.spot] : dw[it.spot];
        ntot++;
        if (got !== it.spot_val) begin
          nbad++;
          $display("FAIL %s spot bit %0d actual=%b expected=%b",
                   it.tag, it.spot, got, it.spot_val);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    ntot++; nbad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    clear_board();
    board = scratch;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R1: all-empty board gives zero outputs
    clear_board();
    apply("R1 empty board", 0, 0, 0);

    // R10: a8 south flag from rook a1; pawn a4 blocks, a3 keeps it
    put(0, 4);
    apply("R10 rook a1 -> a8 south", 56*8+1, 0, 1);
    put(24, 1);
    apply("R10 pawn a4 blocks a8", 56*8+1, 0, 0);
    apply("R4 a3 still sees rook", 16*8+1, 0, 1);
    apply("R4 a5 blocked by pawn", 32*8+1, 0, 0);

    // R3 / R6: queen d4, adjacent diagonal and far orthogonal squares
    clear_board(); put(27, 5);
    apply("R3 queen d4 adjacent e5 SW", 36*8+7, 0, 1);
    apply("R6 d8 south", 59*8+1, 0, 1);
    apply("R6 d1 north", 3*8+0, 0, 1);
    apply("R6 a4 east", 24*8+2, 0, 1);
    apply("R6 h4 west", 31*8+3, 0, 1);

    // R5: bishop only on diagonals
    clear_board(); put(27, 3);
    apply("R5 bishop d4 not orthogonal", 35*8+1, 0, 0);
    apply("R5 bishop d4 diagonal", 36*8+7, 0, 1);

    // R5: pawns, knights, kings give nothing
    clear_board();
    put(10, 1); put(20, 2); put(30, 6); put(40, 7); put(50, 8); put(60, 12);
    apply("R5 non-sliders silent", 19*8+4, 0, 0);

    // R8: black rook h8 flags only black; white vector stays zero
    clear_board(); put(63, 10);
    apply("R8 black rook h8 -> h1 north", 7*8+0, 1, 1);
    apply("R8 white unaffected", 7*8+0, 0, 0);

    // R4: wrong-colour slider blocks
    clear_board(); put(0, 4); put(8, 10);
    apply("R4 black rook a2 blocks white", 56*8+1, 0, 0);

    // R7: zero-length rays on edges stay zero with queens around
    clear_board(); put(38, 5); put(46, 5); put(30, 11);
    apply("R7 h5 east edge", 39*8+2, 0, 0);
    apply("R7 h5 east edge black", 39*8+2, 1, 0);

    // Starting position
    clear_board();
    begin
      int back[8];
      back = '{4, 2, 3, 5, 6, 3, 2, 4};
      for (int f = 0; f < 8; f++) begin
        put(f, back[f]); put(8 + f, 1);
        put(48 + f, 7); put(56 + f, back[f] + 6);
      end
    end
    apply("R4 starting position", -1, 0, 0);

    // R2: random boards
    for (int t = 0; t < 60; t++) begin
      clear_board();
      for (int s = 0; s < NSQ; s++) begin
        int v;
        v = int'($urandom % 24);
        if (v < 12) put(s, v + 1);
      end
      apply("R2 random board", -1, 0, 0);
    end

    repeat (4) @(posedge clk);
    summary();
  end
endmodule